// File: doc/BRIEF.md
# Skew-Free Latch Scan Cell Chain

This block is a scan flip-flop replacement built from two level-sensitive storage stages. A master stage takes either functional data or the scan input. A slave stage copies the master and drives the output, which also feeds the next cell's scan input. Shift, capture and the master-to-slave transfer are all steered by separate control lines that the test program keeps from overlapping. As a result, no test operation depends on how the functional clock is skewed between cells, and cells that act on the rising edge can share a chain with cells that act on the falling edge.

In functional mode the controls are held at master-scan 0, slave-transfer 0, capture strobe 1 and system enable 1. Each cell then acts as an edge-triggered flip-flop on `sys_clk`. The project builds a parameterised chain of such cells. Bit i of `FALL_MASK` selects the falling-edge variant for cell i, and the default of 3'b010 makes cell 1 the falling one. Cell 0 takes `scan_in`, and cell i drives `q[i]`.

Each storage stage is modelled against a sampling clock `clk`. While its enable is high on a `clk` edge the stage loads its data, so it behaves like a transparent latch with one sample of latency. Every control level must therefore stay stable for at least one `clk` cycle.

Top module: `skf_scan_chain`

## Requirements
- R1: While `rst_n` is low on a `clk` edge, every master and slave clears, which gives q=0 and q_n=1 on all cells.
- R2: A master loads its `d_in` bit when its capture window is open. For a rising cell the window is open when `cap_strobe` is high and `sys_clk` is low. For a falling cell it is open when `cap_strobe` is high and `sys_clk` is high.
- R3: While `mscan_pulse` is high, the master of cell 0 loads `scan_in` and the master of cell i loads `q[i-1]`. A scan load takes priority over a capture, and the two must never be active in the same cycle.
- R4: A slave loads its master when `sxfer_pulse` is high, or when `sys_en` is high and the cell's clock phase is closed. The closed phase is `sys_clk` high for a rising cell and `sys_clk` low for a falling cell. At all other times the slave holds.
- R5: In functional mode, a rising cell's `q` takes the `d_in` value that was present before each rising edge of `sys_clk`, and it does not change on falling edges.
- R6: In functional mode, a falling cell's `q` takes the `d_in` value that was present before each falling edge of `sys_clk`, and it does not change on rising edges.
- R7: With `sys_clk`=1 and `cap_strobe`=`sys_en`=0, a pulse on `mscan_pulse` followed by a separate pulse on `sxfer_pulse` moves the chain by exactly one place. After the move, `q[0]`=`scan_in` and `scan_out`=`q[N-1]`. `mscan_pulse` and `sxfer_pulse` are never high together.
- R8: A capture strobe changes only the masters, so `q` keeps its value until a slave-transfer pulse on its own copies the captured data to `q`.
- R9: `q_n` is always the complement of `q`.
- R10: While no load enable is active, toggling `d_in`, `scan_in` or `sys_clk` leaves `q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the storage model |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_clk | input | 1 | Functional clock shared by all cells |
| mscan_pulse | input | 1 | Master scan-load control |
| sxfer_pulse | input | 1 | Slave transfer control |
| cap_strobe | input | 1 | Capture strobe (must be 1 in functional mode) |
| sys_en | input | 1 | System enable for the functional slave path |
| d_in | input | N | Functional data, one bit per cell |
| scan_in | input | 1 | Serial scan data into cell 0 |
| q | output | N | Cell outputs |
| q_n | output | N | Complemented cell outputs |
| scan_out | output | 1 | Serial scan data from the last cell |

## Verification
The bench goes after the mixed-polarity chain. A capture taken with only one `sys_clk` level would leave the falling cell (or the rising cells) holding stale shift data after the observe pulse. A decode that swapped the clock phase for one variant would make that cell act on the wrong functional edge, so its bit would change one half-period off from the edge-by-edge reference. A capture that leaked into the slave would disturb `q` before the observe pulse. A slave that was open during the scan-load pulse would let data ripple through several cells in a single shift, and the serial pattern would arrive shortened at `scan_out`.

// File: rtl/skf_pkg.sv
// Shared types for the skew-free scan cell chain.
package skf_pkg;

    // Which functional clock edge a cell mimics.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_e;

    // Control levels common to every cell in the chain.
    typedef struct packed {
        logic sys_clk;
        logic mscan;
        logic sxfer;
        logic strobe;
        logic sys_en;
    } ctl_t;

    // Per-cell decoded load enables.
    typedef struct packed {
        logic ld_scan;
        logic ld_func;
        logic ld_slave;
    } en_t;

endpackage

// File: rtl/skf_enable_decode.sv
// Turns the shared control levels into the load enables of one cell.
// Assumes: POL picks the clock phase in which the master is open for
// functional data; the slave opens in the opposite phase.
module skf_enable_decode #(
    parameter skf_pkg::edge_e POL = skf_pkg::EDGE_RISE
) (
    input  skf_pkg::ctl_t ctl,
    output skf_pkg::en_t  en
);
    logic clk_open;

    // Phase in which the master accepts functional data.
    if (POL == skf_pkg::EDGE_RISE) begin : g_rise
        assign clk_open = ~ctl.sys_clk;
    end else begin : g_fall
        assign clk_open = ctl.sys_clk;
    end

    // Combine strobe, enable and pulses into the three load enables.
    always_comb begin
        en.ld_scan  = ctl.mscan;
        en.ld_func  = ctl.strobe & clk_open;
        en.ld_slave = (~clk_open & ctl.sys_en) | ctl.sxfer;
    end
endmodule

// File: rtl/skf_master_latch.sv
// Master stage: loads scan data or functional data while enabled.
// Assumes: a scan load and a functional load are never both requested.
module skf_master_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_scan,
    input  logic ld_func,
    input  logic scan_d,
    input  logic func_d,
    output logic m
);
    logic m_r;

    // Level-sensitive storage sampled on clk; the scan path wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       m_r <= 1'b0;
        else if (ld_scan) m_r <= scan_d;
        else if (ld_func) m_r <= func_d;
    end

    assign m = m_r;

    AST_MASTER_RESET: assert property (@(posedge clk) !rst_n |=> (m_r == 1'b0)); // R1
    AST_MASTER_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        ld_scan |=> (m_r == $past(scan_d))); // R3
    AST_MASTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_func && !ld_scan) |=> (m_r == $past(func_d))); // R2
    AST_MASTER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_scan && ld_func)); // R3
    AST_MASTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_scan || ld_func) |=> $stable(m_r)); // R10
endmodule

// File: rtl/skf_slave_latch.sv
// Slave stage: copies the master while enabled, drives q and q_n.
// Assumes: the master value is stable while the slave is open during shift.
module skf_slave_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic ld,
    input  logic m,
    output logic q,
    output logic q_n
);
    logic q_r;
    logic qn_r;

    // True and complement outputs held as separate storage bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r  <= 1'b0;
            qn_r <= 1'b1;
        end else if (ld) begin
            q_r  <= m;
            qn_r <= ~m;
        end
    end

    assign q   = q_r;
    assign q_n = qn_r;

    AST_SLAVE_RESET: assert property (@(posedge clk) !rst_n |=> (q_r == 1'b0)); // R1
    AST_SLAVE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (q_r == $past(m))); // R4
    AST_SLAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q_r)); // R8
    AST_SLAVE_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        (qn_r == ~q_r)); // R9
endmodule

// File: rtl/skf_scan_cell.sv
// One skew-free scan cell: decode, master stage and slave stage.
// Assumes: shared controls are held for at least one clk cycle per level.
module skf_scan_cell #(
    parameter skf_pkg::edge_e POL = skf_pkg::EDGE_RISE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  skf_pkg::ctl_t ctl,
    input  logic          func_d,
    input  logic          scan_d,
    output logic          q,
    output logic          q_n
);
    skf_pkg::en_t en;
    logic         m;

    skf_enable_decode #(.POL(POL)) i_decode (
        .ctl (ctl),
        .en  (en)
    );

    skf_master_latch i_master (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_scan (en.ld_scan),
        .ld_func (en.ld_func),
        .scan_d  (scan_d),
        .func_d  (func_d),
        .m       (m)
    );

    skf_slave_latch i_slave (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (en.ld_slave),
        .m     (m),
        .q     (q),
        .q_n   (q_n)
    );
endmodule

// File: rtl/skf_scan_chain.sv
// Chain of skew-free scan cells with per-cell edge polarity.
// Assumes: cell 0 is nearest scan_in; FALL_MASK bit i selects the
// falling-edge variant for cell i.
module skf_scan_chain #(
    parameter int           N         = 3,
    parameter logic [N-1:0] FALL_MASK = 3'b010
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sys_clk,
    input  logic         mscan_pulse,
    input  logic         sxfer_pulse,
    input  logic         cap_strobe,
    input  logic         sys_en,
    input  logic [N-1:0] d_in,
    input  logic         scan_in,
    output logic [N-1:0] q,
    output logic [N-1:0] q_n,
    output logic         scan_out
);
    localparam int LAST = N - 1;

    skf_pkg::ctl_t ctl;
    logic [N:0]    link;

    // Bundle the shared control levels for every cell.
    always_comb begin
        ctl.sys_clk = sys_clk;
        ctl.mscan   = mscan_pulse;
        ctl.sxfer   = sxfer_pulse;
        ctl.strobe  = cap_strobe;
        ctl.sys_en  = sys_en;
    end

    assign link[0] = scan_in;

    for (genvar i = 0; i < N; i++) begin : g_cell
        localparam skf_pkg::edge_e CELL_POL =
            FALL_MASK[i] ? skf_pkg::EDGE_FALL : skf_pkg::EDGE_RISE;

        skf_scan_cell #(.POL(CELL_POL)) i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctl    (ctl),
            .func_d (d_in[i]),
            .scan_d (link[i]),
            .q      (q[i]),
            .q_n    (q_n[i])
        );

        assign link[i+1] = q[i];
    end

    assign scan_out = link[LAST+1];

    AST_NO_SCAN_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mscan_pulse && sxfer_pulse)); // R7
endmodule

// File: tb/test_skf_scan_chain.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected outputs, a monitor compares.
module test_skf_scan_chain;
    localparam int           N    = 3;
    localparam logic [N-1:0] FALL = 3'b010;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sys_clk = 1'b1;
    logic         mscan_pulse = 1'b0;
    logic         sxfer_pulse = 1'b0;
    logic         cap_strobe = 1'b0;
    logic         sys_en = 1'b0;
    logic [N-1:0] d_in = '0;
    logic         scan_in = 1'b0;
    logic [N-1:0] q;
    logic [N-1:0] q_n;
    logic         scan_out;

    typedef struct {
        string        tag;
        logic [N-1:0] exp;
    } item_t;

    item_t        sb[$];
    int           checks = 0;
    int           failures = 0;
    logic [N-1:0] model = '0;
    bit           done = 1'b0;

    skf_scan_chain #(.N(N), .FALL_MASK(FALL)) i_skf_scan_chain (
        .clk(clk), .rst_n(rst_n), .sys_clk(sys_clk),
        .mscan_pulse(mscan_pulse), .sxfer_pulse(sxfer_pulse),
        .cap_strobe(cap_strobe), .sys_en(sys_en), .d_in(d_in),
        .scan_in(scan_in), .q(q), .q_n(q_n), .scan_out(scan_out)
    );

    always #4 clk = ~clk;

    // Monitor: pop one expectation per falling clk edge and compare.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (q !== it.exp) begin
                    failures++;
                    $display("FAIL %s q actual=%b expected=%b", it.tag, q, it.exp);
                end
                checks++;
                if (q_n !== ~it.exp) begin
                    failures++;
                    $display("FAIL R9 q_n actual=%b expected=%b", q_n, ~it.exp);
                end
                checks++;
                if (scan_out !== it.exp[N-1]) begin
                    failures++;
                    $display("FAIL R7 scan_out actual=%b expected=%b", scan_out, it.exp[N-1]);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One slot of the 60-unit test period (10 units) is two clk cycles.
    task automatic slots(input int n);
        idle(2 * n);
    endtask

    task automatic expect_q(input logic [N-1:0] e, input string tag);
        item_t it;
        it.tag = tag;
        it.exp = e;
        sb.push_back(it);
        idle(2);
    endtask

    // Shift cycle: scan-load pulse at slot 2, transfer pulse at slot 4.
    task automatic shift_one(input logic si);
        scan_in = si;
        slots(2);
        mscan_pulse = 1'b1;
        slots(1);
        mscan_pulse = 1'b0;
        slots(1);
        sxfer_pulse = 1'b1;
        slots(1);
        sxfer_pulse = 1'b0;
        slots(1);
        model = {model[N-2:0], si};
    endtask

    // Functional clock change; the model follows flip-flop semantics.
    task automatic func_clk(input logic lvl);
        if (lvl && !sys_clk)  model = (model & FALL) | (d_in & ~FALL);
        if (!lvl && sys_clk)  model = (model & ~FALL) | (d_in & FALL);
        sys_clk = lvl;
        slots(2);
    endtask

    initial begin
        idle(3);
        expect_q('0, "R1 reset");
        rst_n = 1'b1;
        idle(2);

        // R7: shift 1,0,1 through the chain, checking each step.
        shift_one(1'b1); expect_q(model, "R7 shift1");
        shift_one(1'b0); expect_q(model, "R7 shift2");
        shift_one(1'b1); expect_q(model, "R7 shift3");
        shift_one(1'b1); expect_q(model, "R3 shift4");

        // R10: no enable active, toggle data, scan input and functional clock.
        d_in = 3'b010; scan_in = 1'b0; sys_clk = 1'b0; slots(2);
        d_in = 3'b101; scan_in = 1'b1; sys_clk = 1'b1; slots(2);
        expect_q(model, "R10 hold");

        // R2/R8: capture in both clock phases so both polarities load.
        d_in = 3'b010;
        sys_clk = 1'b0; slots(1);
        cap_strobe = 1'b1; slots(2); cap_strobe = 1'b0; slots(1);
        sys_clk = 1'b1; slots(1);
        cap_strobe = 1'b1; slots(2); cap_strobe = 1'b0; slots(1);
        expect_q(model, "R8 q unchanged after capture");
        // R4: observe step with the transfer pulse only.
        sxfer_pulse = 1'b1; slots(1); sxfer_pulse = 1'b0; slots(1);
        model = d_in;
        expect_q(model, "R2 R4 captured data observed");

        // Shift the captured pattern out and a new one in.
        shift_one(1'b0); expect_q(model, "R7 unload1");
        shift_one(1'b0); expect_q(model, "R7 unload2");
        shift_one(1'b1); expect_q(model, "R7 unload3");

        // R5/R6: functional mode as edge-triggered flip-flops.
        d_in = 3'b110;
        cap_strobe = 1'b1; sys_en = 1'b1; slots(2);
        expect_q(model, "R5 R6 mode entry no edge");
        func_clk(1'b0); expect_q(model, "R6 falling edge");
        func_clk(1'b1); expect_q(model, "R5 rising edge");
        d_in = 3'b001; slots(1);
        func_clk(1'b0); expect_q(model, "R6 falling edge d2");
        func_clk(1'b1); expect_q(model, "R5 rising edge d2");
        d_in = 3'b111; slots(1);
        func_clk(1'b0); expect_q(model, "R6 falling edge d3");
        d_in = 3'b000; slots(1);
        func_clk(1'b1); expect_q(model, "R5 rising edge d3");

        // R1: reset in the middle of a run.
        cap_strobe = 1'b0; sys_en = 1'b0;
        rst_n = 1'b0; idle(2);
        model = '0;
        expect_q(model, "R1 mid-run reset");
        rst_n = 1'b1; idle(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is counted as one failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule